// File: doc/BRIEF.md
# Timer Time-Base Selector with Divider

This block chooses the time base for a set of timers from seven candidate rates and sends out a one-cycle clock-enable pulse at the chosen rate. Each candidate rate arrives as an enable input that is high for one cycle per period. Sources 0 to 2 have fixed rates and pass through without division. Sources 3 to 6 go through an 8-bit divider, and a divisor code of 0 means a division by 256.

The divided sources and Counter0 share a resource, so both cannot be active at once. A configuration guard rejects any write that would combine a divided source with an enabled Counter0, in either order. It also rejects the unused source code. A rejected write leaves the configuration as it was and sets a sticky error flag. A new source or divisor is applied only at the next output pulse, so no short period ever appears.

Top module: `tbase_sel`

## Requirements
- R1: After reset the configured source is 2 (the fastest fixed rate). Counter0 is disabled, the error flag is clear, the blocked flag is clear, and `tick_o` stays low while no base tick is present.
- R2: While the applied source is 0, 1 or 2, `tick_o` equals that source's base tick in the same cycle, whatever the divisor.
- R3: While the applied source is 3 to 6 with divisor code d in 1..255, `tick_o` fires once for every d ticks of that source. The first pulse comes d ticks after the source is applied.
- R4: Divisor code 0 divides by 256.
- R5: A written source and divisor become the applied ones only in the cycle after an output pulse. The down-counter reloads with the new divisor at that pulse.
- R6: `ctr0_blocked_o` is high exactly while the configured source is 3 to 6.
- R7: A write that enables Counter0 while a divided source is configured is rejected. `cfg_err_o` is set and `ctr0_en_o` stays low.
- R8: A write that selects a divided source while Counter0 is enabled is rejected. `cfg_err_o` is set and `cur_src_o` is unchanged.
- R9: A source write with code 7 is rejected and sets `cfg_err_o`.
- R10: When source and Counter0 writes arrive in the same cycle, they are judged on the combined result. A conflict rejects both writes.
- R11: `cfg_err_o` stays set until `err_clr_i` is asserted. A new rejection in the clear cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 7 | One enable per candidate rate, bit i = source i |
| src_sel_i | input | 3 | Source code to write |
| div_i | input | 8 | Divisor code to write with the source (0 = 256) |
| src_wr_i | input | 1 | Source/divisor write strobe |
| ctr0_en_i | input | 1 | Requested Counter0 enable value |
| ctr0_wr_i | input | 1 | Counter0 enable write strobe |
| err_clr_i | input | 1 | Clears the error flag |
| tick_o | output | 1 | Clock-enable pulse at the selected rate |
| cur_src_o | output | 3 | Configured source code |
| ctr0_en_o | output | 1 | Counter0 enabled state |
| ctr0_blocked_o | output | 1 | Counter0 unavailable (divided source configured) |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
A wrong divider count shows up on `tick_o` within one divided period, which is at most 256 selected ticks. A wrong applied-source register makes `tick_o` follow the wrong base line at the next selected tick. A fault in the guard registers is visible on `cur_src_o`, `ctr0_en_o`, `ctr0_blocked_o` or `cfg_err_o` in the cycle after the offending write. The bench compares every output against a model in every cycle, so each of these faults is reported at its first visible cycle.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  function automatic logic src_divided(input int unsigned code,
                                       input int unsigned n_fixed,
                                       input int unsigned n_src);
    return (code >= n_fixed) && (code < n_src);
  endfunction

endpackage

// File: rtl/tbase_cfg_guard.sv
module tbase_cfg_guard #(
  parameter int unsigned NUM_SRC     = 7,
  parameter int unsigned NUM_FIXED   = 3,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SRC_W       = 3,
  parameter int unsigned DEFAULT_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             src_wr_i,
  input  logic             ctr0_en_i,
  input  logic             ctr0_wr_i,
  input  logic             err_clr_i,
  output logic [SRC_W-1:0] cfg_src_o,
  output logic [DIV_W-1:0] cfg_div_o,
  output logic             ctr0_en_o,
  output logic             err_o
);
  import tbs_pkg::*;

  logic [SRC_W-1:0] cfg_src_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic             ctr0_q, err_q;

  logic [SRC_W-1:0] cand_src;
  logic             cand_ctr, bad_code, conflict, any_wr, reject;

  // judge the configuration that would result from this cycle's writes
  always_comb begin
    cand_src = src_wr_i  ? src_sel_i : cfg_src_q;
    cand_ctr = ctr0_wr_i ? ctr0_en_i : ctr0_q;
    bad_code = src_wr_i && (32'(src_sel_i) >= NUM_SRC);
    conflict = src_divided(32'(cand_src), NUM_FIXED, NUM_SRC) && cand_ctr;
    any_wr   = src_wr_i || ctr0_wr_i;
    reject   = any_wr && (bad_code || conflict);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_src_q <= SRC_W'(DEFAULT_SRC);
      cfg_div_q <= '0;
      ctr0_q    <= 1'b0;
    end else if (any_wr && !reject) begin
      if (src_wr_i) begin
        cfg_src_q <= src_sel_i;
        cfg_div_q <= div_i;
      end
      if (ctr0_wr_i) ctr0_q <= ctr0_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (reject)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign cfg_src_o = cfg_src_q;
  assign cfg_div_o = cfg_div_q;
  assign ctr0_en_o = ctr0_q;
  assign err_o     = err_q;

endmodule

// File: rtl/tbase_divider.sv
module tbase_divider #(
  parameter int unsigned NUM_SRC     = 7,
  parameter int unsigned NUM_FIXED   = 3,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SRC_W       = 3,
  parameter int unsigned DEFAULT_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] base_tick_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  output logic               tick_o
);
  import tbs_pkg::*;

  logic [SRC_W-1:0]   act_src_q;
  logic [DIV_W-1:0]   cnt_q;
  logic [NUM_SRC-1:0] sel_vec;
  logic               sel_tick, act_fixed, pulse;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign sel_vec[i] = base_tick_i[i] && (act_src_q == SRC_W'(i));
  end

  assign sel_tick  = |sel_vec;
  assign act_fixed = !src_divided(32'(act_src_q), NUM_FIXED, NUM_SRC);
  assign pulse     = sel_tick && (act_fixed || (cnt_q == '0));

  // new config is applied only on a pulse; code 0 reloads all ones (= /256)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_src_q <= SRC_W'(DEFAULT_SRC);
      cnt_q     <= '0;
    end else if (pulse) begin
      act_src_q <= cfg_src_i;
      cnt_q     <= src_divided(32'(cfg_src_i), NUM_FIXED, NUM_SRC)
                   ? cfg_div_i - DIV_W'(1) : '0;
    end else if (sel_tick) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = pulse;

endmodule

// File: rtl/tbase_sel.sv
module tbase_sel #(
  parameter int unsigned NUM_SRC     = 7,
  parameter int unsigned NUM_FIXED   = 3,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DEFAULT_SRC = 2,
  localparam int unsigned SRC_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] base_tick_i,
  input  logic [SRC_W-1:0]   src_sel_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               src_wr_i,
  input  logic               ctr0_en_i,
  input  logic               ctr0_wr_i,
  input  logic               err_clr_i,
  output logic               tick_o,
  output logic [SRC_W-1:0]   cur_src_o,
  output logic               ctr0_en_o,
  output logic               ctr0_blocked_o,
  output logic               cfg_err_o
);
  import tbs_pkg::*;

  logic [SRC_W-1:0] cfg_src;
  logic [DIV_W-1:0] cfg_div;

  tbase_cfg_guard #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .DIV_W(DIV_W),
    .SRC_W(SRC_W), .DEFAULT_SRC(DEFAULT_SRC)
  ) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sel_i (src_sel_i),
    .div_i     (div_i),
    .src_wr_i  (src_wr_i),
    .ctr0_en_i (ctr0_en_i),
    .ctr0_wr_i (ctr0_wr_i),
    .err_clr_i (err_clr_i),
    .cfg_src_o (cfg_src),
    .cfg_div_o (cfg_div),
    .ctr0_en_o (ctr0_en_o),
    .err_o     (cfg_err_o)
  );

  tbase_divider #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .DIV_W(DIV_W),
    .SRC_W(SRC_W), .DEFAULT_SRC(DEFAULT_SRC)
  ) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_tick_i (base_tick_i),
    .cfg_src_i   (cfg_src),
    .cfg_div_i   (cfg_div),
    .tick_o      (tick_o)
  );

  assign cur_src_o      = cfg_src;
  assign ctr0_blocked_o = src_divided(32'(cfg_src), NUM_FIXED, NUM_SRC);

endmodule

// File: rtl/tbase_sel_chk.sv
module tbase_sel_chk #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned SRC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] base_tick_i,
  input logic               src_wr_i,
  input logic               ctr0_wr_i,
  input logic               err_clr_i,
  input logic               tick_o,
  input logic [SRC_W-1:0]   cur_src_o,
  input logic               ctr0_en_o,
  input logic               ctr0_blocked_o,
  input logic               cfg_err_o
);

  // R7
  no_ctr0_while_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctr0_en_o && ctr0_blocked_o));

  // R11
  err_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(src_wr_i || ctr0_wr_i));

  // R8
  reject_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> ($stable(cur_src_o) && $stable(ctr0_en_o)));

  // R9
  src_code_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cur_src_o) < NUM_SRC);

  // R11
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !src_wr_i && !ctr0_wr_i) |=> !cfg_err_o);

  // R2
  tick_has_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (|base_tick_i));

endmodule

bind tbase_sel tbase_sel_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .base_tick_i    (base_tick_i),
  .src_wr_i       (src_wr_i),
  .ctr0_wr_i      (ctr0_wr_i),
  .err_clr_i      (err_clr_i),
  .tick_o         (tick_o),
  .cur_src_o      (cur_src_o),
  .ctr0_en_o      (ctr0_en_o),
  .ctr0_blocked_o (ctr0_blocked_o),
  .cfg_err_o      (cfg_err_o)
);

// File: tb/sim_tbase_sel.sv
module sim_tbase_sel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bt = '0;
  logic [2:0] ss = '0;
  logic [7:0] sd = '0;
  logic       sw = 1'b0, ce = 1'b0, cw = 1'b0, clr = 1'b0;
  logic       tick, c_en, blk, err;
  logic [2:0] csrc;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // model state
  int m_csrc = 2, m_cdiv = 0, m_asrc = 2, m_cnt = 0;
  bit m_ctr = 0, m_err = 0;

  always #2 clk = ~clk;

  tbase_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(bt), .src_sel_i(ss), .div_i(sd),
    .src_wr_i(sw), .ctr0_en_i(ce), .ctr0_wr_i(cw), .err_clr_i(clr),
    .tick_o(tick), .cur_src_o(csrc), .ctr0_en_o(c_en),
    .ctr0_blocked_o(blk), .cfg_err_o(err)
  );

  function automatic bit is_div(int s);
    return s >= 3 && s <= 6;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare all outputs, advance the model
  task automatic step(logic [6:0] b, bit w_s, int s, int d, bit w_c, bit c,
                      bit cl, string ttag, string ctag);
    bit t, cand_c, rej;
    int cand_s;
    @(negedge clk);
    bt = b; sw = w_s; ss = 3'(s); sd = 8'(d); cw = w_c; ce = c; clr = cl;
    #1;
    t = b[m_asrc] && (!is_div(m_asrc) || m_cnt == 0);
    chk(is_div(m_asrc) ? ttag : "R2", int'(tick), int'(t));
    chk(ctag, int'(csrc), m_csrc);
    chk(ctag, int'(c_en), int'(m_ctr));
    chk("R6", int'(blk), int'(is_div(m_csrc)));
    chk(ctag, int'(err), int'(m_err));
    if (b[m_asrc]) begin
      if (t) begin
        m_asrc = m_csrc;
        m_cnt = is_div(m_csrc) ? ((m_cdiv + 255) % 256) : 0;
      end else m_cnt = m_cnt - 1;
    end
    cand_s = w_s ? s : m_csrc;
    cand_c = w_c ? c : m_ctr;
    rej = (w_s || w_c) && ((w_s && s == 7) || (is_div(cand_s) && cand_c));
    if ((w_s || w_c) && !rej) begin
      if (w_s) begin m_csrc = s; m_cdiv = d; end
      if (w_c) m_ctr = c;
    end
    if (rej) m_err = 1;
    else if (cl) m_err = 0;
  endtask

  task automatic idle(int n, logic [6:0] b, string tt, string ct);
    for (int i = 0; i < n; i++) step(b, 0, 0, 0, 0, 0, 0, tt, ct);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int pulses;
    void'($urandom(32'd5731));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(3, 7'b0, "R1", "R1");
    // R2 fixed source 2 follows its own line, divisor irrelevant
    idle(6, 7'b0000100, "R2", "R1");
    idle(4, 7'b1111011, "R2", "R1");
    // R5 write source 4 /3; applies only after next pulse of source 2
    step(7'b0010000, 1, 4, 3, 0, 0, 0, "R5", "R6");
    idle(3, 7'b0010000, "R5", "R6");
    idle(1, 7'b0010100, "R5", "R6");
    idle(12, 7'b0010000, "R3", "R6");
    // R7 enable Counter0 while divided
    step(7'b0, 0, 0, 0, 1, 1, 0, "R3", "R7");
    idle(2, 7'b0, "R3", "R7");
    // R11 clear
    step(7'b0, 0, 0, 0, 0, 0, 1, "R3", "R11");
    idle(1, 7'b0, "R3", "R11");
    // R4 divisor 0 on source 3
    step(7'b0, 1, 3, 0, 0, 0, 0, "R5", "R6");
    idle(3, 7'b0010000, "R5", "R6");
    pulses = 0;
    for (int i = 0; i < 520; i++) begin
      step(7'b0001000, 0, 0, 0, 0, 0, 0, "R4", "R4");
      if (tick) pulses++;
    end
    chk("R4", pulses, 2);
    // R3 divisor 1: every tick
    step(7'b0, 1, 6, 1, 0, 0, 0, "R3", "R6");
    idle(260, 7'b1001000, "R3", "R3");
    // R8 fixed source, Counter0 on, then try divided
    step(7'b0, 1, 0, 9, 0, 0, 0, "R3", "R6");
    idle(2, 7'b1000001, "R5", "R6");
    step(7'b0, 0, 0, 0, 1, 1, 0, "R2", "R8");
    step(7'b0, 1, 5, 2, 0, 0, 0, "R2", "R8");
    idle(2, 7'b0000001, "R2", "R8");
    // R11 new rejection in clear cycle keeps flag
    step(7'b0, 1, 3, 2, 0, 0, 1, "R2", "R11");
    idle(1, 7'b0, "R2", "R11");
    step(7'b0, 0, 0, 0, 0, 0, 1, "R2", "R11");
    // R9 code 7
    step(7'b0, 1, 7, 4, 0, 0, 0, "R2", "R9");
    idle(1, 7'b0, "R2", "R9");
    step(7'b0, 0, 0, 0, 0, 0, 1, "R2", "R9");
    // R10 simultaneous: disable Counter0 and pick divided is fine
    step(7'b0, 1, 5, 2, 1, 0, 0, "R2", "R10");
    idle(1, 7'b0, "R2", "R10");
    // R10 simultaneous conflict rejects both
    step(7'b0, 1, 1, 2, 1, 1, 0, "R2", "R10");
    step(7'b0, 1, 6, 2, 1, 1, 0, "R2", "R10");
    idle(2, 7'b0, "R2", "R10");
    // random
    for (int i = 0; i < 6000; i++) begin
      step(7'($urandom), ($urandom % 12) == 0, $urandom % 8, $urandom % 5,
           ($urandom % 12) == 0, 1'($urandom), ($urandom % 9) == 0, "R3", "R10");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule